// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands one bit per clock cycle. On a start request it captures the multiplicand into a register that stays fixed for the whole operation. It places the multiplier in the low half of a double-width product register and clears the high half. It then performs one add-and-shift iteration per cycle until every multiplier bit has been consumed.

In each iteration the least significant product bit decides whether the multiplicand is added to the upper half of the product. The add uses a single adder as wide as one operand. The full product register then moves right by one place, and the adder's carry-out enters at the top. No separate multiplier register and no double-width adder exist. A caller raises `start` for one cycle while the block is idle, waits for `done`, and reads `product`.

Top module: `seq_mul`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `busy`, `done` and `product` to zero.
- R2: When `start` is high and `busy` is low at a clock edge, the next cycle shows `busy` high and `product` equal to the multiplier in bits W-1..0 with zeros in bits 2W-1..W.
- R3: After an accepted start, `busy` stays high for exactly W consecutive cycles. `done` is high for exactly one cycle, which is the cycle right after `busy` falls, and never while `busy` is high.
- R4: In the cycle `done` is high, `product` equals the unsigned product of the two operands sampled at the accepted start.
- R5: The carry out of each upper-half addition is preserved, so the all-ones by all-ones product (2^2W - 2^(W+1) + 1) is exact.
- R6: While `busy` is high, `start`, `multiplicand` and `multiplier` are ignored: neither the result nor the W-cycle duration changes.
- R7: While idle with `start` low, `product` holds its last value.
- R8: A zero multiplicand or a zero multiplier gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | W | Unsigned multiplicand, sampled on accepted start |
| multiplier | input | W | Unsigned multiplier, sampled on accepted start |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2W | Product register (final value valid from `done`) |

## Verification
A wrong iteration count shows at once in the length of the `busy` window and in the `done` timing. It also leaves the product scaled by a power of two in the `done` cycle. A dropped adder carry corrupts only operand pairs whose upper-half sums overflow, so the all-ones pair and the wide random values expose it in the `done` cycle of that operation. A multiplicand register that reloads while busy gives a wrong result when the operand pins change mid-operation. A wrong load value appears in `product` one cycle after start.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_t;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  import mul_pkg::*;

  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_t      state;
  logic [CW-1:0]   iter;
  logic            last;

  assign busy = (state == ST_RUN);
  assign load = start && !busy;
  assign step = busy;
  assign last = (iter == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      iter  <= '0;
      done  <= 1'b0;
    end else begin
      done <= step && last;
      if (load) begin
        state <= ST_RUN;
        iter  <= '0;
      end else if (step) begin
        iter <= iter + 1'b1;
        if (last) state <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/mul_adder.sv
module mul_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W:0]   sum
);
  assign sum = {1'b0, x} + {1'b0, y};
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] mcand_in,
  input  logic [W-1:0] mplier_in,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] mcand_q;
  logic [W-1:0] addend;
  logic [W:0]   upper_sum;

  assign addend = prod[0] ? mcand_q : '0;

  mul_adder #(.W(W)) u_add (
    .x   (prod[2*W-1:W]),
    .y   (addend),
    .sum (upper_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      prod    <= '0;
    end else if (load) begin
      mcand_q <= mcand_in;
      prod    <= {{W{1'b0}}, mplier_in};
    end else if (step) begin
      prod <= {upper_sum, prod[W-1:1]};
    end
  end
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  logic load;
  logic step;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .mcand_in  (multiplicand),
    .mplier_in (multiplier),
    .prod      (product)
  );
endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [W-1:0]   multiplicand,
  input logic [W-1:0]   multiplier,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  localparam int CW = $clog2(W) + 1;

  logic [CW-1:0] run_len;
  logic [W-1:0]  a_cap;
  logic [W-1:0]  b_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      a_cap   <= '0;
      b_cap   <= '0;
    end else if (start && !busy) begin
      run_len <= '0;
      a_cap   <= multiplicand;
      b_cap   <= multiplier;
    end else if (busy) begin
      run_len <= run_len + 1'b1;
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && product == {{W{1'b0}}, $past(multiplier)}));

  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r3_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_run_length: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len == CW'(W)));

  a_r4_product: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == ((2*W)'(a_cap) * (2*W)'(b_cap))));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product));
endmodule

bind seq_mul mul_chk #(.W(W)) u_mul_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .busy         (busy),
  .done         (done),
  .product      (product)
);

// File: tb/test_seq_mul.sv
module test_seq_mul;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   multiplicand = '0;
  logic [W-1:0]   multiplier = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  seq_mul #(.W(W)) i_seq_mul (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    return (2*W)'(a) * (2*W)'(b);
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // disturb: at this busy cycle, drive start and flipped operands (0 = none)
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                         input int disturb, input string req);
    int cycles;
    logic [2*W-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    start = 1'b1; multiplicand = a; multiplier = b;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", 64'(busy), 64'd1);
    check("R2 load value", product, {{W{1'b0}}, b});
    cycles = 0;
    while (busy === 1'b1 && cycles < 1000) begin
      cycles++;
      if (cycles == disturb) begin
        start = 1'b1; multiplicand = ~a; multiplier = ~b;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check("R3 busy length", 64'(cycles), 64'(W));
    check("R3 done after busy", 64'(done), 64'd1);
    check(req, product, exp);
    @(negedge clk);
    check("R3 done single cycle", 64'(done), 64'd0);
    check("R7 product held", product, exp);
    multiplicand = $urandom; multiplier = $urandom;
    @(negedge clk);
    check("R7 held with pins changing", product, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy reset", 64'(busy), 64'd0);
    check("R1 done reset", 64'(done), 64'd0);
    check("R1 product reset", product, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    run_mul(32'd2, 32'd11, 0, "R4 small product");
    run_mul(32'd0, 32'hFFFF_FFFF, 0, "R8 zero multiplicand");
    run_mul(32'hDEAD_BEEF, 32'd0, 0, "R8 zero multiplier");
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R5 all ones carry");
    run_mul(32'h8000_0000, 32'h8000_0000, 0, "R5 top bits");
    run_mul(32'hFFFF_FFFF, 32'd1, 0, "R4 identity");
    run_mul(32'h1234_5678, 32'h9ABC_DEF0, 5, "R6 start ignored while busy");
    run_mul(32'hCAFE_F00D, 32'h7FFF_FFFF, 31, "R6 late disturbance ignored");
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 4 == 1) ra = ra | 32'hFFFF_0000;
      run_mul(ra, rb, (i % 5 == 0) ? 3 : 0, "R4 random product");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule